// File: doc/BRIEF.md
# Synchronous Decimal Digit Counter

This block holds one decimal digit in four state bits and steps it through 0 to 9 on a single shared clock. Each update is set by fixed exclusive-OR next-state equations on the individual bits, not by a compare-and-clear, so every code from 10 to 15 also has a defined successor. Any illegal code returns to the legal range within two enabled clock edges.

A count-enable input gates every update. A synchronous reset clears the digit. A terminal-count output marks the enabled step out of 9, so an outside chain of digits can feed it to the enable of the next decade. A separate flag reports when the stored code is not a decimal digit.

The state is a named enumeration. DIG0 to DIG9 are the legal digits. BAD10 to BAD15 are the illegal codes.

The transitions are:
- COUNT: DIGn goes to DIGn+1 for n from 0 to 8.
- WRAP: DIG9 goes to DIG0.
- ESCAPE: BAD10 goes to BAD11, BAD12 to BAD13, and BAD14 to BAD15.
- RECOVER: BAD11 goes to DIG6, BAD13 to DIG4, and BAD15 to DIG2.
- HOLD: any state keeps its value while enable is low.
- CLEAR: any state goes to DIG0 on reset.

Top module: `bcd_digit`

## Requirements
- R1: With `srst` high at a rising clock edge, `count` becomes 0 on that edge, whatever `cnt_en` is.
- R2: With `srst` low, `cnt_en` high and `count` in 0..8, `count` becomes count+1 on the edge.
- R3: With `srst` low, `cnt_en` high and `count` equal to 9, `count` becomes 0 on the edge.
- R4: With `srst` low and `cnt_en` low, `count` keeps its value on the edge.
- R5: `term` is high exactly when `count` is 9 and `cnt_en` is high, in the same cycle (combinational).
- R6: `bad` is high exactly when `count` holds 10..15, in the same cycle (combinational).
- R7: The enabled recovery paths are exactly 10→11→6, 12→13→4 and 14→15→2.
- R8: From any illegal code, at most two enabled edges bring `count` back to 0..9, and a legal code never steps to an illegal one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock; state changes on its rising edge |
| srst | input | 1 | Synchronous reset, active high, overrides enable |
| cnt_en | input | 1 | Count enable; low holds the digit |
| count | output | 4 | Stored digit, bit 3 most significant (weights 8,4,2,1) |
| term | output | 1 | Terminal count: digit 9 while enabled |
| bad | output | 1 | Stored code is outside 0..9 |

## Verification
`count` changes one register stage after the edge that samples `srst` and `cnt_en`. `term` and `bad` are combinational and are due in the same cycle as the state and enable that produce them.

The bench drives its inputs on the falling edge and checks all three outputs 1 ns later. It then advances its own digit model on the rising edge, so every comparison sees the state produced by exactly one edge.

Illegal codes are placed into the state register while reset is held, and reset is released before the next edge. This lets each recovery path be traced edge by edge from a known start.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
    localparam int DIGIT_W  = 4;
    localparam int LAST_DIG = 9;

    typedef enum logic [DIGIT_W-1:0] {
        DIG0  = 4'd0,
        DIG1  = 4'd1,
        DIG2  = 4'd2,
        DIG3  = 4'd3,
        DIG4  = 4'd4,
        DIG5  = 4'd5,
        DIG6  = 4'd6,
        DIG7  = 4'd7,
        DIG8  = 4'd8,
        DIG9  = 4'd9,
        BAD10 = 4'd10,
        BAD11 = 4'd11,
        BAD12 = 4'd12,
        BAD13 = 4'd13,
        BAD14 = 4'd14,
        BAD15 = 4'd15
    } dig_state_t;
endpackage

// File: rtl/bcd_next.sv
// Next-state equations, bit by bit, in exclusive-OR form.
module bcd_next
    import bcd_pkg::*;
(
    input  dig_state_t cur,
    output dig_state_t nxt
);
    logic w1, w2, w4, w8;
    logic [DIGIT_W-1:0] d;

    assign w1 = cur[0];
    assign w2 = cur[1];
    assign w4 = cur[2];
    assign w8 = cur[3];

    always_comb begin
        d[0] = ~w1;
        d[1] = w2 ^ (w1 & ~w8);
        d[2] = w4 ^ (w1 & w2);
        d[3] = w8 ^ ((w1 & w8) | (w1 & w2 & w4));
        nxt  = dig_state_t'(d);
    end
endmodule

// File: rtl/bcd_decode.sv
// Output decode from the current state.
module bcd_decode
    import bcd_pkg::*;
(
    input  dig_state_t cur,
    input  logic       en,
    output logic       term,
    output logic       bad
);
    always_comb begin
        bad = cur[3] & (cur[2] | cur[1]);
    end

    always_comb begin
        term = 1'b0;
        unique case (cur)
            DIG9:    term = en;
            default: term = 1'b0;
        endcase
    end
endmodule

// File: rtl/bcd_digit.sv
module bcd_digit
    import bcd_pkg::*;
(
    input  logic               clk,
    input  logic               srst,
    input  logic               cnt_en,
    output logic [DIGIT_W-1:0] count,
    output logic               term,
    output logic               bad
);
    dig_state_t state_q;
    dig_state_t state_nx;

    bcd_next u_next (
        .cur (state_q),
        .nxt (state_nx)
    );

    bcd_decode u_dec (
        .cur  (state_q),
        .en   (cnt_en),
        .term (term),
        .bad  (bad)
    );

    always_ff @(posedge clk) begin
        if (srst)
            state_q <= DIG0;
        else if (cnt_en)
            state_q <= state_nx;
    end

    assign count = state_q;

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (srst)
        !cnt_en |=> $stable(count)); // R4

    AST_STEP_UP: assert property (@(posedge clk) disable iff (srst)
        (cnt_en && count < 4'd9) |=> count == $past(count) + 4'd1); // R2

    AST_TERM_WRAP: assert property (@(posedge clk) disable iff (srst)
        term |=> count == 4'd0); // R3

    AST_ODD_ESCAPE: assert property (@(posedge clk) disable iff (srst)
        (bad && count[0] && cnt_en) |=> !bad); // R8

    AST_EVEN_ESCAPE: assert property (@(posedge clk) disable iff (srst)
        (bad && !count[0] && cnt_en) |=> (bad && count[0])); // R7

    AST_LEGAL_CLOSED: assert property (@(posedge clk) disable iff (srst)
        (!bad && cnt_en) |=> !bad); // R8
endmodule

// File: tb/sim_bcd_digit.sv
`timescale 1ns/1ps
module sim_bcd_digit;
    logic       clk = 1'b0;
    logic       srst;
    logic       cnt_en;
    logic [3:0] count;
    logic       term;
    logic       bad;

    int n_cmp = 0;
    int n_bad = 0;
    int model = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    bcd_digit u0 (
        .clk    (clk),
        .srst   (srst),
        .cnt_en (cnt_en),
        .count  (count),
        .term   (term),
        .bad    (bad)
    );

    function automatic int ref_next(int cur, bit r, bit e);
        if (r) return 0;
        if (!e) return cur;
        case (cur)
            10: return 11;
            11: return 6;
            12: return 13;
            13: return 4;
            14: return 15;
            15: return 2;
            default: return (cur + 1) % 10;
        endcase
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Drive at the falling edge, compare 1 ns later, advance the model at the rising edge.
    task automatic cyc(bit r, bit e, string tag);
        srst   = r;
        cnt_en = e;
        #1;
        chk({tag, " count"}, int'(count), model);
        chk("R5 term", int'(term), (model == 9 && e) ? 1 : 0);
        chk("R6 bad", int'(bad), (model >= 10) ? 1 : 0);
        @(posedge clk);
        model = ref_next(model, r, e);
        @(negedge clk);
    endtask

    task automatic plant(int code);
        srst   = 1'b1;
        cnt_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        force u0.state_q = bcd_pkg::dig_state_t'(code[3:0]);
        #0.1;
        release u0.state_q;
        srst  = 1'b0;
        model = code;
    endtask

    initial begin
        srst   = 1'b1;
        cnt_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        model = 0;
        cyc(1, 1, "R1 reset");
        // Plain counting through wrap, twice.
        for (int i = 0; i < 22; i++) cyc(0, 1, (model == 9) ? "R3 wrap" : "R2 step");
        // Hold with enable low at several digits.
        for (int i = 0; i < 4; i++) cyc(0, 0, "R4 hold");
        for (int i = 0; i < 5; i++) cyc(0, (i % 2) == 1, "R4 gated");
        // Reset wins over enable in mid-count.
        cyc(0, 1, "R2 step");
        cyc(1, 1, "R1 reset priority");
        cyc(0, 0, "R1 after reset");
        // Every illegal code: flag, exact path, return within two edges.
        for (int c = 10; c < 16; c++) begin
            plant(c);
            cyc(0, 0, "R4 hold illegal");
            cyc(0, 1, "R7 path");
            cyc(0, 1, "R7 path");
            chk("R8 recovered", (model < 10) ? int'(count < 4'd10) : 1, 1);
            cyc(0, 1, "R2 after recovery");
        end
        // Reset out of an illegal code.
        plant(13);
        cyc(1, 0, "R1 from illegal");
        cyc(0, 1, "R2 step");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule